// File: doc/BRIEF.md
# Auxiliary Event Time Snapshot

This block timestamps two asynchronous external event inputs against a free-running 64-bit system time value. One input serves the slave-side auxiliary event and the other the master-side auxiliary event. Each input is brought into the clock domain by a two-flop synchroniser, and a rising-edge detector follows it. When a rising edge is seen on an enabled channel whose status bit is clear, the block latches the current `systime_i` into that channel's snapshot register and sets the channel's status bit.

Software reaches the block through a small word-addressed register port. It enables each channel in a control word and reads the snapshots as low and high 32-bit words. It acknowledges events by writing ones to the shared event word. An active-low interrupt stays asserted while any status bit is set and its channel enable is also set. The time counter itself lives outside the block and arrives on an input port.

Top module: `aux_evt_snap`

## Requirements
- R1: After reset the control word, the event word and all four snapshot words read zero, and `irq_no` is high.
- R2: Word address 0 is the control word. Bit 2 enables slave-side capture and bit 3 enables master-side capture. Only these two bits are stored, and every other bit reads zero.
- R3: A rising level on an event input is sampled at a clock edge n. The snapshot then takes the `systime_i` value present at edge n+2, and the status bit sets at that same edge.
- R4: An edge on a channel whose enable bit is clear sets no status bit and leaves the snapshot unchanged.
- R5: Word address 1 is the event word, with the slave status at bit 2 and the master status at bit 3. Writing 1 to a status bit clears it. Writing 0 to a bit has no effect. Both bits may be cleared in one write.
- R6: While a channel's status bit is set, further edges on that channel leave its snapshot and status unchanged.
- R7: The slave snapshot reads at word 2 (low) and word 3 (high). The master snapshot reads at word 4 (low) and word 5 (high). Word addresses 6 and 7 read zero.
- R8: `irq_no` is low exactly while some status bit is set together with its enable bit. Clearing the enable masks the interrupt without clearing the status bit.
- R9: An input held high produces one capture only. A new capture requires the input to go low and rise again. The two channels capture independently, including on the same cycle.
- R10: If an edge arrives in the same cycle as an acknowledge of a status bit that is still set, the edge is dropped. The status bit clears and the snapshot keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| systime_i | input | 64 | Running system time in ticks |
| evt_i | input | 2 | Asynchronous event inputs: bit 0 slave side, bit 1 master side |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The capture path is driven with short pulses, with levels held high for many cycles, and with pulses on both inputs in the same cycle. The short pulses pin down the three-edge latency, and the held levels separate edge detection from level detection. The simultaneous pulses show that the channels do not interfere with each other. Pulses on disabled channels, repeat pulses while a status bit is pending, and an acknowledge that coincides with an edge each probe a separate gating term of the status update. Writes of zero to the event word, and enable toggling while status is pending, show that acknowledge and interrupt masking are distinct. The system time steps its high word on every cycle, so a swapped or stale half of a snapshot shows up in the reads.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;
  localparam int unsigned N_CH      = 2;  // 0: slave side, 1: master side
  localparam int unsigned CH_BIT0   = 2;  // first enable/status bit position
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_EVT     = 1;
  localparam int unsigned SNAP_BASE = 2;
endpackage

// File: rtl/aux_evt_sync.sv
module aux_evt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  // sh_q[STAGES-1] is the last synchronised sample, sh_q[STAGES] the one before
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/aux_evt_chan.sv
module aux_evt_chan #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              en_i,
  input  logic              ack_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              pend_o,
  output logic [TIME_W-1:0] snap_o
);
  logic cap;

  // new capture only into a free slot
  assign cap = rise_i & en_i & ~pend_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      snap_o <= '0;
    end else begin
      pend_o <= (pend_o & ~ack_i) | cap;
      if (cap) snap_o <= time_i;
    end
  end
endmodule

// File: rtl/aux_evt_snap.sv
module aux_evt_snap
  import aux_snap_pkg::*;
#(
  parameter int unsigned TIME_W      = 64,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] systime_i,
  input  logic [N_CH-1:0]   evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_no
);
  localparam int unsigned WORDS = TIME_W / DATA_W;

  logic [N_CH-1:0]             en_q;
  logic [N_CH-1:0]             pend;
  logic [N_CH-1:0]             rise;
  logic [N_CH-1:0]             ack;
  logic [N_CH-1:0][TIME_W-1:0] snap;

  logic wr_ctrl, wr_evt;
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_W'(A_CTRL));
  assign wr_evt  = reg_we_i && (reg_addr_i == ADDR_W'(A_EVT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (wr_ctrl) en_q <= reg_wdata_i[CH_BIT0 +: N_CH];
  end

  assign ack = wr_evt ? reg_wdata_i[CH_BIT0 +: N_CH] : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    aux_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(evt_i[c]),
      .rise_o (rise[c])
    );
    aux_evt_chan #(.TIME_W(TIME_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (rise[c]),
      .en_i   (en_q[c]),
      .ack_i  (ack[c]),
      .time_i (systime_i),
      .pend_o (pend[c]),
      .snap_o (snap[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(A_CTRL)) reg_rdata_o[CH_BIT0 +: N_CH] = en_q;
    if (reg_addr_i == ADDR_W'(A_EVT))  reg_rdata_o[CH_BIT0 +: N_CH] = pend;
    for (int c = 0; c < N_CH; c++) begin
      for (int k = 0; k < WORDS; k++) begin
        if (reg_addr_i == ADDR_W'(SNAP_BASE + c * WORDS + k))
          reg_rdata_o = snap[c][k*DATA_W +: DATA_W];
      end
    end
  end

  assign irq_no = ~|(pend & en_q);
endmodule

// File: rtl/aux_evt_snap_chk.sv
module aux_evt_snap_chk
  import aux_snap_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [TIME_W-1:0]           systime_i,
  input logic                        reg_we_i,
  input logic [ADDR_W-1:0]           reg_addr_i,
  input logic [DATA_W-1:0]           reg_wdata_i,
  input logic                        irq_no,
  input logic [N_CH-1:0]             en_q,
  input logic [N_CH-1:0]             pend,
  input logic [N_CH-1:0][TIME_W-1:0] snap
);
  for (genvar c = 0; c < N_CH; c++) begin : g_chk
    assert_cap_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend[c]) |-> $past(en_q[c]));

    assert_snap_time_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend[c]) |-> (snap[c] == $past(systime_i)));

    assert_hold_snap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend[c] && $past(pend[c])) |-> $stable(snap[c]));

    assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == ADDR_W'(A_EVT) && reg_wdata_i[CH_BIT0+c] && pend[c])
        |=> !pend[c]);

    assert_irq_on_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend[c]) |-> !irq_no);
  end
endmodule

bind aux_evt_snap aux_evt_snap_chk #(
  .TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .systime_i  (systime_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_no     (irq_no),
  .en_q       (en_q),
  .pend       (pend),
  .snap       (snap)
);

// File: tb/aux_evt_snap_bench.sv
module aux_evt_snap_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] systime_i = '0;
  logic [1:0]  evt_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_no;

  always #4 clk_i = ~clk_i;

  aux_evt_snap u_aux_evt_snap (.*);

  int total = 0, bad = 0;
  string phase = "R1";
  logic [63:0] st = 64'h0000_0001_FFFF_FFF0;

  // behavioural reference state
  logic [1:0]  en_m = '0, sts_m = '0;
  logic [63:0] snap_m [2] = '{64'd0, 64'd0};
  bit          hist [2][$];  // front = newest sample

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {28'd0, en_m, 2'b00};
      3'd1: return {28'd0, sts_m, 2'b00};
      3'd2: return snap_m[0][31:0];
      3'd3: return snap_m[0][63:32];
      3'd4: return snap_m[1][31:0];
      3'd5: return snap_m[1][63:32];
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [2:0] a, input logic [31:0] wd,
                      input logic [1:0] ev);
    logic [1:0] cap, ack;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd; evt_i = ev; systime_i = st;
    @(posedge clk_i);
    for (int c = 0; c < 2; c++) begin
      bit older2 = (hist[c].size() > 1) ? hist[c][1] : 1'b0;
      bit older3 = (hist[c].size() > 2) ? hist[c][2] : 1'b0;
      cap[c] = older2 && !older3 && en_m[c] && !sts_m[c];
      ack[c] = we && a == 3'd1 && wd[2+c];
      hist[c].push_front(ev[c]);
      if (hist[c].size() > 4) void'(hist[c].pop_back());
      if (cap[c]) snap_m[c] = st;
    end
    sts_m = (sts_m & ~ack) | cap;
    if (we && a == 3'd0) en_m = wd[3:2];
    st = st + 64'h0000_0001_0000_0007;
    #2;
    check($sformatf("rdata@%0d", a), reg_rdata_o, exp_rd(a));
    check("irq_no", {31'd0, irq_no}, {31'd0, ~|(sts_m & en_m)});
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] ev);
    step(1'b0, a, 32'd0, ev);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1'b1;
    // R1: reset values on every word
    for (int a = 0; a < 8; a++) rd(3'(a), 2'b00);

    phase = "R4";  // disabled channels ignore edges
    repeat (3) rd(3'd1, 2'b11);
    repeat (4) rd(3'd2, 2'b00);
    rd(3'd4, 2'b00);

    phase = "R2";
    step(1'b1, 3'd0, 32'hFFFF_FFFF, 2'b00);
    rd(3'd0, 2'b00);
    step(1'b1, 3'd0, 32'h0000_0004, 2'b00);
    rd(3'd0, 2'b00);

    phase = "R3";  // slave pulse, latency and value
    repeat (3) rd(3'd2, 2'b01);
    repeat (2) rd(3'd3, 2'b00);
    rd(3'd1, 2'b00);

    phase = "R6";  // pending status blocks overwrite
    repeat (2) rd(3'd2, 2'b01);
    repeat (4) rd(3'd2, 2'b00);
    rd(3'd3, 2'b00);

    phase = "R5";
    step(1'b1, 3'd1, 32'h0, 2'b00);
    rd(3'd1, 2'b00);
    step(1'b1, 3'd1, 32'h8, 2'b00);
    rd(3'd1, 2'b00);
    step(1'b1, 3'd1, 32'h4, 2'b00);
    rd(3'd1, 2'b00);

    phase = "R9";  // held level, then simultaneous edges
    step(1'b1, 3'd0, 32'hC, 2'b00);
    repeat (10) rd(3'd4, 2'b10);
    rd(3'd5, 2'b10);
    step(1'b1, 3'd1, 32'h8, 2'b10);
    repeat (6) rd(3'd1, 2'b10);
    repeat (3) rd(3'd4, 2'b00);
    repeat (2) rd(3'd1, 2'b11);
    repeat (3) rd(3'd2, 2'b00);
    rd(3'd4, 2'b00);
    rd(3'd5, 2'b00);

    phase = "R8";  // enable masks irq, status kept
    step(1'b1, 3'd0, 32'h0, 2'b00);
    rd(3'd1, 2'b00);
    step(1'b1, 3'd0, 32'h8, 2'b00);
    rd(3'd1, 2'b00);
    step(1'b1, 3'd1, 32'hC, 2'b00);
    rd(3'd1, 2'b00);

    phase = "R10";  // edge in the acknowledge cycle is dropped
    step(1'b1, 3'd0, 32'hC, 2'b00);
    repeat (2) rd(3'd1, 2'b01);
    repeat (3) rd(3'd2, 2'b00);
    repeat (2) rd(3'd1, 2'b01);
    step(1'b1, 3'd1, 32'h4, 2'b01);
    repeat (3) rd(3'd1, 2'b00);
    rd(3'd2, 2'b00);
    repeat (2) rd(3'd1, 2'b01);
    repeat (3) rd(3'd2, 2'b00);

    phase = "R7";
    for (int a = 0; a < 8; a++) rd(3'(a), 2'b00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog %s: actual=running expected=finished", phase);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule